// File: doc/BRIEF.md
# SPI Program-Verify Handshake Controller

This block sits on the chip side of a test link and takes byte data from an external tester over a mode-0 SPI connection. Two extra sideband wires sit next to the four SPI wires. The tester raises a request line (`pv_req`) to ask the chip to program the byte it has just sent and then check that byte itself. The chip answers on a result line (`vfy_ok`), so the tester never reads the data back or compares it. A small byte-wide flash cell model stands in for the array. Programming can only clear bits. Each program pulse clears at most one bit that still differs from the target, so the number of pulses, and with it the busy time, changes from byte to byte.

All four SPI inputs are resampled into the system clock domain. A command state machine decodes each selection with the states C_IDLE, C_CMD, C_ADDR, C_PROG, C_READ and C_SKIP:
- C_IDLE moves to C_CMD when chip select goes low.
- C_CMD moves to C_ADDR for a known command. Any other command sends it to C_SKIP.
- C_ADDR moves to C_PROG or C_READ, depending on the command.
- Every state falls back to C_IDLE when chip select goes high.

The pulse engine has the states E_IDLE, E_PULSE and E_VERIFY:
- E_IDLE moves to E_PULSE on a request edge.
- E_PULSE moves to E_VERIFY after each pulse.
- E_VERIFY goes back to E_PULSE on a mismatch while pulses remain. It returns to E_IDLE on a match or when the pulse limit is reached.

Top module: `pvh_top`

## Requirements
- R1: After reset every cell holds 0xFF, `vfy_ok` is low, and `miso` is high outside a read stream (engine ready).
- R2: SPI is mode 0 with the most significant bit first, and bits are sampled on rising `sclk` while `cs_n` is low. The first byte of a selection is a command: 0x02 starts a program stream and 0x03 starts a read stream. The second byte sets the current address from its low ADDR_W bits.
- R3: In a program stream each further byte replaces the pending data byte. The array does not change until a request edge arrives.
- R4: A rising edge on `pv_req` while the engine is idle starts one program-verify cycle on the pending byte at the current address. While the cycle runs, `miso` (outside a read stream) and `vfy_ok` are both low.
- R5: Each pulse lasts PULSE_LEN clocks and is followed by one verify clock. A pulse clears only the lowest bit that is set in the cell but clear in the target, and never sets a bit. A byte that can be reached therefore takes max(1, k) pulses, where k is the number of bits still to clear, and about that many times (PULSE_LEN+1) clocks.
- R6: When the cell matches the target, the cycle ends with `vfy_ok` high and `miso` high.
- R7: A target that needs a 0 turned back into 1 gets MAX_PULSES (16) pulses and then ends with `vfy_ok` low and `miso` high. The cell is left holding the old value AND the target.
- R8: The current address steps by one after every finished cycle, whether it passed or failed, and wraps at the top of the array.
- R9: A read stream drives the stored byte at the current address on `miso`, most significant bit first. Bit 7 is valid before the first rising edge, and the line changes after falling edges. The address steps by one per byte and wraps.
- R10: A `pv_req` edge that arrives while a cycle is running is ignored. It starts no second cycle and does not step the address.
- R11: After an unknown command, the rest of the selection has no effect on the array or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data from the tester |
| miso | output | 1 | Read data in a read stream, otherwise the engine-ready flag |
| pv_req | input | 1 | Program-and-verify request, acts on its rising edge |
| vfy_ok | output | 1 | High after a verified byte, low while busy or after a failure |

## Verification
The assertions assume that `sclk` and `mosi` stay stable for several system clocks around each SPI edge. This gives the resampling stages time to see every edge once. They also assume that `pv_req` is held long enough for a clean edge to be seen. The bench holds each SPI half period for eight system clocks and keeps `pv_req` high until the ready flag returns. It changes chip select only while `sclk` is low. It never raises a request mid-byte, so the pending byte is always a complete one.

// File: rtl/pvh_pkg.sv
package pvh_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ    = 8'h03;

    typedef enum logic [2:0] {
        C_IDLE, C_CMD, C_ADDR, C_PROG, C_READ, C_SKIP
    } cmd_state_t;

    typedef enum logic [1:0] {
        E_IDLE, E_PULSE, E_VERIFY
    } eng_state_t;
endpackage

// File: rtl/pvh_spi_port.sv
module pvh_spi_port
    import pvh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sel,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_bit
);
    localparam int BW = $clog2(BYTE_W);

    logic [1:0]        cs_q;
    logic [2:0]        sck_q;
    logic [1:0]        mosi_q;
    logic [BW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              sck_rise;
    logic              sck_fall;

    assign sel      = ~cs_q[1];
    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];
    assign rx_byte  = rx_sr;
    assign tx_bit   = tx_sr[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 2'b11;
            sck_q  <= '0;
            mosi_q <= '0;
        end else begin
            cs_q   <= {cs_q[0], cs_n};
            sck_q  <= {sck_q[1:0], sclk};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            byte_done <= 1'b0;
        end else if (!sel) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_q[1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BW'(BYTE_W-1))
                    byte_done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (!sel)
            tx_sr <= '0;
        else if (tx_load)
            tx_sr <= tx_data;
        else if (sck_fall && bit_cnt != '0)
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end

    // R2
    byte_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(sck_rise));
endmodule

// File: rtl/pvh_cell_array.sv
module pvh_cell_array
    import pvh_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_en,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic [BYTE_W-1:0] pg_target,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [BYTE_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [BYTE_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] pending;
    logic [BYTE_W-1:0] lowest;

    assign pending = mem[pg_addr] & ~pg_target;
    assign lowest  = pending & (~pending + 1'b1);
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (pg_en) begin
            mem[pg_addr] <= mem[pg_addr] & ~lowest;
        end
    end

    logic              chk_v;
    logic [ADDR_W-1:0] chk_addr;
    logic [BYTE_W-1:0] chk_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v    <= 1'b0;
            chk_addr <= '0;
            chk_old  <= '0;
        end else begin
            chk_v    <= pg_en;
            chk_addr <= pg_addr;
            chk_old  <= mem[pg_addr];
        end
    end

    // R5
    one_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> (($countones(mem[chk_addr] ^ chk_old) <= 1)
                   && ((mem[chk_addr] & ~chk_old) == '0)));
endmodule

// File: rtl/pvh_pulse_engine.sv
module pvh_pulse_engine
    import pvh_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PULSE_LEN  = 8,
    parameter int MAX_PULSES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTE_W-1:0] cell_data,
    output logic              pg_en,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [BYTE_W-1:0] pg_target,
    output logic              busy,
    output logic              vfy_ok,
    output logic              done
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam int PW = $clog2(MAX_PULSES + 1);

    eng_state_t        st, nxt;
    logic [2:0]        req_q;
    logic              req_rise;
    logic [CW-1:0]     cyc;
    logic [PW-1:0]     pulses;
    logic [BYTE_W-1:0] tgt;
    logic [ADDR_W-1:0] wa;
    logic              ok_q;
    logic              last_cyc;
    logic              match;
    logic              at_limit;

    assign req_rise = req_q[1] & ~req_q[2];
    assign last_cyc = (cyc == CW'(PULSE_LEN - 1));
    assign match    = (cell_data == tgt);
    assign at_limit = (pulses == PW'(MAX_PULSES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= {req_q[1:0], req};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            E_IDLE:   if (req_rise) nxt = E_PULSE;
            E_PULSE:  if (last_cyc) nxt = E_VERIFY;
            E_VERIFY: nxt = (match || at_limit) ? E_IDLE : E_PULSE;
            default:  nxt = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc    <= '0;
            pulses <= '0;
            tgt    <= '0;
            wa     <= '0;
            ok_q   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                E_IDLE: if (req_rise) begin
                    tgt    <= data_in;
                    wa     <= addr_in;
                    cyc    <= '0;
                    pulses <= '0;
                    ok_q   <= 1'b0;
                end
                E_PULSE: begin
                    cyc <= cyc + 1'b1;
                    if (last_cyc) pulses <= pulses + 1'b1;
                end
                E_VERIFY: begin
                    cyc <= '0;
                    if (match || at_limit) begin
                        ok_q <= match;
                        done <= 1'b1;
                    end
                end
                default: cyc <= '0;
            endcase
        end
    end

    always_comb begin
        pg_en     = (st == E_PULSE) && last_cyc;
        pg_addr   = wa;
        pg_target = tgt;
        busy      = (st != E_IDLE);
        vfy_ok    = ok_q;
    end

    // R4
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !vfy_ok);
    // R7
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PW'(MAX_PULSES));
    // R10
    hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nxt != E_IDLE) |=> $stable(tgt) && $stable(wa));
endmodule

// File: rtl/pvh_top.sv
module pvh_top
    import pvh_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PULSE_LEN  = 8,
    parameter int MAX_PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    input  logic pv_req,
    output logic vfy_ok
);
    cmd_state_t        st, nxt;
    logic              sel;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_bit;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_data;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] ld_addr;
    logic [BYTE_W-1:0] pend;
    logic              rd_mode;
    logic              pg_en;
    logic [ADDR_W-1:0] pg_addr;
    logic [BYTE_W-1:0] pg_target;
    logic [BYTE_W-1:0] cell_data;
    logic              eng_busy;
    logic              eng_done;

    pvh_spi_port u_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .tx_load(tx_load), .tx_data(tx_data), .sel(sel),
        .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
    );

    pvh_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .pg_addr(pg_addr),
        .pg_target(pg_target), .ra_addr(ld_addr), .ra_data(tx_data),
        .rb_addr(pg_addr), .rb_data(cell_data)
    );

    pvh_pulse_engine #(
        .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .MAX_PULSES(MAX_PULSES)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .req(pv_req), .data_in(pend),
        .addr_in(addr), .cell_data(cell_data), .pg_en(pg_en),
        .pg_addr(pg_addr), .pg_target(pg_target), .busy(eng_busy),
        .vfy_ok(vfy_ok), .done(eng_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!sel) begin
            nxt = C_IDLE;
        end else begin
            unique case (st)
                C_IDLE: nxt = C_CMD;
                C_CMD:  if (byte_done)
                            nxt = (rx_byte == OP_PROGRAM || rx_byte == OP_READ)
                                  ? C_ADDR : C_SKIP;
                C_ADDR: if (byte_done) nxt = rd_mode ? C_READ : C_PROG;
                C_PROG, C_READ, C_SKIP: nxt = st;
                default: nxt = C_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_addr = (st == C_ADDR) ? rx_byte[ADDR_W-1:0] : addr;
        tx_load = byte_done && ((st == C_ADDR && rd_mode) || st == C_READ);
        miso    = (st == C_READ) ? tx_bit : ~eng_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            pend    <= '0;
            rd_mode <= 1'b0;
        end else begin
            if (st == C_CMD && byte_done)
                rd_mode <= (rx_byte == OP_READ);
            if (st == C_PROG && byte_done)
                pend <= rx_byte;
            if (tx_load)
                addr <= ld_addr + 1'b1;
            else if (st == C_ADDR && byte_done)
                addr <= ld_addr;
            else if (eng_done)
                addr <= addr + 1'b1;
        end
    end

    // R3
    idle_no_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !pg_en);
    // R11
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_SKIP && !eng_done) |=> $stable(addr));
    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !byte_done) |=> addr == $past(addr) + 1'b1);
endmodule

// File: tb/sim_pvh_top.sv
module sim_pvh_top;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int ADDR_W     = 4;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PULSE_LEN  = 8;
    localparam int MAX_PULSES = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic pv_req = 1'b0;
    logic miso;
    logic vfy_ok;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl [DEPTH];
    int wa = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pvh_top #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .MAX_PULSES(MAX_PULSES)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .pv_req(pv_req), .vfy_ok(vfy_ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input int act, input int exp);
        total++;
        if (act < exp - 2 || act > exp + 2) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(H);
            r[i] = miso;
            sclk = 1'b1;
            wait_clk(H);
            sclk = 1'b0;
        end
        wait_clk(H);
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic select_off();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    // Runs one request; optional second edge while busy (R10).
    task automatic pv_run(input logic retrigger, output int cycles);
        bit seen_low = 0;
        pv_req = 1'b1;
        cycles = 0;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            cycles++;
            if (cycles == 6) begin
                chk("R4 vfy_ok low while busy", int'(vfy_ok), 0);
                chk("R4 ready low while busy", int'(miso), 0);
            end
            if (retrigger && cycles == 12) pv_req = 1'b0;
            if (retrigger && cycles == 18) pv_req = 1'b1;
            if (miso === 1'b0) seen_low = 1;
            if (seen_low && miso === 1'b1) break;
        end
        pv_req = 1'b0;
        wait_clk(4);
    endtask

    task automatic prog_byte(input logic [7:0] b, input logic retrigger);
        logic [7:0] r;
        int cyc;
        int k;
        bit pass;
        int np;
        xfer(b, r);
        pass = ((~mdl[wa] & b) == 8'h00);
        k = ones(mdl[wa] & ~b);
        np = pass ? ((k == 0) ? 1 : k) : MAX_PULSES;
        pv_run(retrigger, cyc);
        chk_near(pass ? "R5 pulse time" : "R7 pulse limit time", cyc,
                 np * (PULSE_LEN + 1) + 3);
        chk(pass ? "R6 pass result" : "R7 fail result", int'(vfy_ok), pass ? 1 : 0);
        chk("R6 ready after cycle", int'(miso), 1);
        mdl[wa] = mdl[wa] & b;
        wa = (wa + 1) % DEPTH;
    endtask

    task automatic read_check(input int start, input int n, input string tag);
        logic [7:0] r;
        select_on();
        xfer(8'h03, r);
        xfer(8'(start), r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            chk(tag, int'(r), int'(mdl[(start + i) % DEPTH]));
        end
        select_off();
    endtask

    task automatic t_reset();
        chk("R1 vfy_ok after reset", int'(vfy_ok), 0);
        chk("R1 ready after reset", int'(miso), 1);
        read_check(0, DEPTH, "R1 erased contents");
    endtask

    task automatic t_program_pass();
        logic [7:0] r;
        select_on();
        xfer(8'h02, r);
        xfer(8'h00, r);
        wa = 0;
        prog_byte(8'hA5, 1'b0);
        prog_byte(8'hFF, 1'b0);
        prog_byte(8'h00, 1'b0);
        prog_byte(8'h3C, 1'b0);
        select_off();
        read_check(0, 4, "R8 R9 programmed stream");
    endtask

    task automatic t_program_fail();
        logic [7:0] r;
        select_on();
        xfer(8'h02, r);
        xfer(8'h03, r);
        wa = 3;
        prog_byte(8'h1D, 1'b0);
        prog_byte(8'h10, 1'b0);
        prog_byte(8'hFF, 1'b0);
        select_off();
        read_check(3, 3, "R7 R8 contents after failures");
    endtask

    task automatic t_busy_ignore();
        logic [7:0] r;
        select_on();
        xfer(8'h02, r);
        xfer(8'h08, r);
        wa = 8;
        prog_byte(8'h81, 1'b1);
        prog_byte(8'h7E, 1'b0);
        select_off();
        read_check(8, 3, "R10 single step on busy edge");
    endtask

    task automatic t_pending_only();
        logic [7:0] r;
        select_on();
        xfer(8'h02, r);
        xfer(8'h05, r);
        xfer(8'h00, r);
        xfer(8'h12, r);
        select_off();
        read_check(5, 1, "R3 no write without request");
    endtask

    task automatic t_unknown();
        logic [7:0] r;
        select_on();
        xfer(8'h55, r);
        xfer(8'h00, r);
        xfer(8'h00, r);
        select_off();
        chk("R11 ready after unknown", int'(miso), 1);
        read_check(0, DEPTH, "R11 array untouched");
    endtask

    task automatic t_wrap();
        read_check(DEPTH - 1, 3, "R9 read wrap");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_program_pass();
        t_program_fail();
        t_busy_ignore();
        t_pending_only();
        t_unknown();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule